// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is the slave side of a byte-oriented serial port that opens a 256-entry command and address space to a host. The space holds a window of clock registers, a reserved stretch inside that window, and a user RAM window. A mode input picks one of two framings. The first is a 4-wire SPI form with separate data in and data out, sent most significant bit first. The second is a 3-wire form on one shared data line, sent least significant bit first. A chip-enable frames each transaction. The first byte carries the direction and the start address. One or more data bytes follow, and the address steps after each one.

The register file and the RAM sit outside the block. The block reaches them through a 7-bit register address, a single-cycle write strobe with its data byte, and a single-cycle read strobe. The read data returns combinationally in the same cycle. For the shared-line mode the block drives a serial output together with an output-enable, and the pad logic outside merges the two. All serial inputs are taken as already synchronous to `clk`. Each SCLK half period must last at least 4 `clk` cycles. CE must stay high for at least 3 `clk` cycles after the last sampling edge of a write.

Top module: `serial_reg_port`

## Requirements
- R1: The first complete byte after CE rises is the command byte. Bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 6:0 form the start address driven on `regAddr`.
- R2: With `spiMode`=1, bits travel MSB first. The SCLK level seen when CE rises is taken as the idle level. The block samples `sdi` on each SCLK edge that returns to the idle level, and it updates `sdo` on each edge that leaves the idle level.
- R3: With `spiMode`=0, bits travel LSB first. `sdi` is sampled on SCLK rising edges and `sdo` is updated on SCLK falling edges.
- R4: `sdoEn` is 0 in four cases: while CE is low, during the command byte, during any write transaction, and until the first read data bit is presented. From that point until CE falls it is 1.
- R5: Each complete data byte in a write transaction produces exactly one single-cycle `regWr` pulse, carrying the byte on `regWrData` and the current address on `regAddr`. `regWr` and `regRd` never pulse together.
- R6: In a read transaction the byte for each address is fetched by a `regRd` pulse. The fetch happens right after the command byte, or right after the previous data byte completes, so the byte is ready before the next output edge.
- R7: After each data byte the address advances by one, and it keeps advancing for as long as CE stays high.
- R8: In the clock window, the read address wraps from 1Fh back to 00h and the write address wraps from 9Fh back to 80h.
- R9: In the RAM window, the read address wraps from 7Fh back to 20h and the write address wraps from FFh back to A0h.
- R10: Reserved read addresses 12h–1Fh return 0 and give no `regRd` pulse. Writes to 92h–9Fh give no `regWr` pulse.
- R11: CE low clears the transfer state. A partial byte left when CE falls is dropped and gives no write. The next transaction starts again with a command byte.
- R12: After reset, `sdoEn`, `regWr` and `regRd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiMode | input | 1 | 1: 4-wire MSB-first framing, 0: 3-wire LSB-first framing |
| ce | input | 1 | Transaction frame, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block (the shared line in 3-wire mode) |
| sdo | output | 1 | Serial data out of the block |
| sdoEn | output | 1 | Drive enable for `sdo` |
| regAddr | output | 7 | Register/RAM index for the current access |
| regWr | output | 1 | Single-cycle write strobe |
| regWrData | output | 8 | Byte to write |
| regRd | output | 1 | Single-cycle read strobe |
| regRdData | input | 8 | Byte returned for `regAddr` in the same cycle |

## Verification
The bench builds the block with its default windows: the clock window ends at 1Fh, the reserved stretch starts at 12h and the RAM starts at 20h. With this 128-address map it can write every one of the 128 write addresses and read back every read address. The write pass uses 4-wire framing with both idle levels. The read-back runs twice, once in 3-wire framing and once in 4-wire framing. Burst transactions that cross each wrap point in both directions check the wrap targets. Aborts partway through a byte, during both a write and a read, check that partial bytes are dropped.

// File: rtl/serPortPkg.sv
package serPortPkg;
  // Strobes from the control to the datapath, valid for one clk cycle.
  typedef struct packed {
    logic rxSample;  // take one bit from sdi
    logic txLoad;    // load the outgoing byte
    logic txZero;    // load zero in place of regRdData
    logic txShift;   // present the next bit on sdo
    logic clear;     // frame closed: release the line
  } dpStrobes_t;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_t;
endpackage

// File: rtl/serEdgeSense.sv
module serEdgeSense (
  input  logic clk,
  input  logic rstN,
  input  logic spiMode,
  input  logic ce,
  input  logic sclk,
  output logic ceActive,
  output logic sampleEdge,
  output logic shiftEdge
);
  logic sclkQ;
  logic ceQ;
  logic idleQ;
  logic anyEdge;
  logic toIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      ceQ   <= 1'b0;
      idleQ <= 1'b0;
    end else begin
      sclkQ <= sclk;
      ceQ   <= ce;
      if (ce && !ceQ) idleQ <= sclk;
    end
  end

  assign ceActive = ce && ceQ;
  assign anyEdge  = ceActive && (sclk != sclkQ);
  assign toIdle   = (sclk == idleQ);

  always_comb begin
    if (spiMode) sampleEdge = anyEdge && toIdle;
    else         sampleEdge = anyEdge && sclk;
    shiftEdge = anyEdge && !sampleEdge;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceActive && $past(ceActive)) |-> $stable(idleQ));
endmodule

// File: rtl/serCtrl.sv
module serCtrl
  import serPortPkg::*;
#(
  parameter logic [6:0] CLK_TOP  = 7'h1F,
  parameter logic [6:0] RSV_BASE = 7'h12,
  parameter logic [6:0] RAM_BASE = 7'h20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceActive,
  input  logic       sampleEdge,
  input  logic       shiftEdge,
  input  logic [7:0] rxByteNext,
  output dpStrobes_t strb,
  output logic [6:0] regAddr,
  output logic       regWr,
  output logic [7:0] regWrData,
  output logic       regRd
);
  localparam logic [6:0] TOP_IDX = 7'h7F;

  phase_t     phase;
  logic [2:0] bitCnt;
  logic [7:0] addr;
  logic [7:0] wrDataQ;
  logic       fetchPend;
  logic       wrPend;
  logic       byteDone;
  logic       inRsv;

  function automatic logic [7:0] stepAddr(input logic [7:0] a);
    logic [6:0] idx;
    idx = a[6:0];
    if (idx == CLK_TOP)      stepAddr = {a[7], 7'h00};
    else if (idx == TOP_IDX) stepAddr = {a[7], RAM_BASE};
    else                     stepAddr = {a[7], idx + 7'd1};
  endfunction

  assign byteDone = sampleEdge && (bitCnt == 3'd7);
  assign inRsv    = (addr[6:0] >= RSV_BASE) && (addr[6:0] <= CLK_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_CMD;
      bitCnt    <= 3'd0;
      addr      <= 8'h00;
      wrDataQ   <= 8'h00;
      fetchPend <= 1'b0;
      wrPend    <= 1'b0;
    end else if (!ceActive) begin
      phase     <= PH_CMD;
      bitCnt    <= 3'd0;
      fetchPend <= 1'b0;
      wrPend    <= 1'b0;
    end else begin
      fetchPend <= 1'b0;
      wrPend    <= 1'b0;
      if (sampleEdge) bitCnt <= bitCnt + 3'd1;
      if (byteDone) begin
        unique case (phase)
          PH_CMD: begin
            addr      <= rxByteNext;
            phase     <= rxByteNext[7] ? PH_WRITE : PH_READ;
            fetchPend <= !rxByteNext[7];
          end
          PH_WRITE: begin
            wrPend  <= 1'b1;
            wrDataQ <= rxByteNext;
          end
          default: begin
            addr      <= stepAddr(addr);
            fetchPend <= 1'b1;
          end
        endcase
      end
      if (wrPend) addr <= stepAddr(addr);
    end
  end

  assign regAddr   = addr[6:0];
  assign regWr     = wrPend && !inRsv;
  assign regWrData = wrDataQ;
  assign regRd     = fetchPend && !inRsv;

  always_comb begin
    strb          = '0;
    strb.rxSample = sampleEdge;
    strb.txLoad   = fetchPend;
    strb.txZero   = inRsv;
    strb.txShift  = shiftEdge && (phase == PH_READ);
    strb.clear    = !ceActive;
  end

  // R5
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regRd));
  // R1
  wr_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> (addr[7] && phase == PH_WRITE));
  // R1
  rd_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRd |-> (!addr[7] && phase == PH_READ));
  // R11
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ceActive |=> (bitCnt == 3'd0 && phase == PH_CMD));
  // R7
  step_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPend && ceActive) |=> (addr != $past(addr)));
endmodule

// File: rtl/serDatapath.sv
module serDatapath
  import serPortPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiMode,
  input  logic       sdi,
  input  dpStrobes_t strb,
  input  logic [7:0] rdData,
  output logic [7:0] rxByteNext,
  output logic       sdo,
  output logic       sdoEn
);
  logic [7:0] rxReg;
  logic [7:0] txReg;
  logic       sdoQ;
  logic       enQ;

  assign rxByteNext = spiMode ? {rxReg[6:0], sdi} : {sdi, rxReg[7:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= 8'h00;
      txReg <= 8'h00;
      sdoQ  <= 1'b0;
      enQ   <= 1'b0;
    end else begin
      if (strb.rxSample) rxReg <= rxByteNext;
      if (strb.clear) begin
        enQ <= 1'b0;
      end else if (strb.txLoad) begin
        txReg <= strb.txZero ? 8'h00 : rdData;
      end else if (strb.txShift) begin
        enQ <= 1'b1;
        if (spiMode) begin
          sdoQ  <= txReg[7];
          txReg <= {txReg[6:0], 1'b0};
        end else begin
          sdoQ  <= txReg[0];
          txReg <= {1'b0, txReg[7:1]};
        end
      end
    end
  end

  assign sdo   = sdoQ;
  assign sdoEn = enQ;

  // R4
  sdo_off_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !sdoEn);
  // R2
  sdo_shift_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdo != $past(sdo)) |-> $past(strb.txShift));
  // R4
  en_rise_on_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoEn) |-> $past(strb.txShift));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import serPortPkg::*;
#(
  parameter logic [6:0] CLK_TOP  = 7'h1F,
  parameter logic [6:0] RSV_BASE = 7'h12,
  parameter logic [6:0] RAM_BASE = 7'h20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiMode,
  input  logic       ce,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdoEn,
  output logic [6:0] regAddr,
  output logic       regWr,
  output logic [7:0] regWrData,
  output logic       regRd,
  input  logic [7:0] regRdData
);
  logic       ceActive;
  logic       sampleEdge;
  logic       shiftEdge;
  logic [7:0] rxByteNext;
  dpStrobes_t strb;

  serEdgeSense u_edge (
    .clk(clk), .rstN(rstN), .spiMode(spiMode), .ce(ce), .sclk(sclk),
    .ceActive(ceActive), .sampleEdge(sampleEdge), .shiftEdge(shiftEdge)
  );

  serCtrl #(.CLK_TOP(CLK_TOP), .RSV_BASE(RSV_BASE), .RAM_BASE(RAM_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceActive(ceActive), .sampleEdge(sampleEdge),
    .shiftEdge(shiftEdge), .rxByteNext(rxByteNext), .strb(strb),
    .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData), .regRd(regRd)
  );

  serDatapath u_dp (
    .clk(clk), .rstN(rstN), .spiMode(spiMode), .sdi(sdi), .strb(strb),
    .rdData(regRdData), .rxByteNext(rxByteNext), .sdo(sdo), .sdoEn(sdoEn)
  );
endmodule

// File: tb/test_serial_reg_port.sv
`timescale 1ns/1ps
module test_serial_reg_port;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiModeR = 1'b1, ceR = 1'b0, sclkR = 1'b0, sdiR = 1'b0;
  logic sdo, sdoEn, regWr, regRd;
  logic [6:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] mem [128];
  int wrCount = 0, rdCount = 0;
  int nChecks = 0, nFail = 0, cycles = 0;
  logic curSpi = 1'b1;

  always #2.5 clk = ~clk;

  serial_reg_port i_serial_reg_port (
    .clk(clk), .rstN(rstN), .spiMode(spiModeR), .ce(ceR), .sclk(sclkR),
    .sdi(sdiR), .sdo(sdo), .sdoEn(sdoEn), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRd(regRd), .regRdData(regRdData)
  );

  assign regRdData = mem[regAddr];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'h5A;
    end else begin
      if (regWr) begin
        mem[regAddr] <= regWrData;
        wrCount <= wrCount + 1;
      end
      if (regRd) rdCount <= rdCount + 1;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) & 8'hFF);
  endfunction
  function automatic bit isRsv(input int a);
    return (a >= 8'h12) && (a <= 8'h1F);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startTxn(input logic spi, input logic cpol);
    curSpi = spi;
    spiModeR = spi;
    sclkR = spi ? cpol : 1'b0;
    tick(4);
    ceR = 1'b1;
    tick(4);
  endtask

  task automatic endTxn();
    tick(6);
    ceR = 1'b0;
    tick(6);
  endtask

  task automatic xfer(input logic [7:0] wb, input int nBits, output logic [7:0] rb,
                      output logic enAny, output logic enAll);
    rb = 8'h00; enAny = 1'b0; enAll = 1'b1;
    for (int i = 0; i < nBits; i++) begin
      int idx;
      idx = curSpi ? 7 - i : i;
      if (curSpi) begin
        sclkR = ~sclkR;
        sdiR = wb[idx];
        tick(HALF);
        rb[idx] = sdo; enAny |= sdoEn; enAll &= sdoEn;
        sclkR = ~sclkR;
        tick(HALF);
      end else begin
        sdiR = wb[idx];
        tick(HALF);
        rb[idx] = sdo; enAny |= sdoEn; enAll &= sdoEn;
        sclkR = 1'b1;
        tick(HALF);
        sclkR = 1'b0;
      end
    end
    if (!curSpi) tick(HALF);
  endtask

  initial begin : watchdog
    wait (cycles > 190000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [7:0] rb;
    logic ea, el;
    int w0, r0;
    tick(5);
    // R12 reset state
    chk(sdoEn == 0 && regWr == 0 && regRd == 0, "R12 reset outputs", {sdoEn, regWr, regRd}, 0);
    rstN = 1'b1;
    tick(5);

    // write sweep, 4-wire, both idle levels (R1 R2 R4 R5 R10)
    for (int a = 0; a < 128; a++) begin
      w0 = wrCount;
      startTxn(1'b1, a[0]);
      xfer(8'h80 | 8'(a), 8, rb, ea, el);
      chk(!ea, "R4 no drive during command", ea, 0);
      xfer(pat(a), 8, rb, ea, el);
      chk(!ea, "R4 no drive during write", ea, 0);
      endTxn();
      chk(wrCount - w0 == (isRsv(a) ? 0 : 1), "R5/R10 write strobe count", wrCount - w0, isRsv(a) ? 0 : 1);
      chk(mem[a] == (isRsv(a) ? 8'h5A : pat(a)), "R2/R5 stored byte", mem[a], isRsv(a) ? 8'h5A : pat(a));
    end

    // read sweep, 3-wire (R3 R4 R6 R10)
    for (int a = 0; a < 128; a++) begin
      r0 = rdCount;
      startTxn(1'b0, 1'b0);
      xfer(8'(a), 8, rb, ea, el);
      chk(!ea, "R4 no drive during command", ea, 0);
      xfer(8'h00, 8, rb, ea, el);
      chk(el, "R4 drive during read data", el, 1);
      chk(rb == (isRsv(a) ? 8'h00 : pat(a)), "R3/R6/R10 read byte", rb, isRsv(a) ? 0 : pat(a));
      endTxn();
      chk(sdoEn == 0, "R4 released after CE low", sdoEn, 0);
      if (a >= 8'h12 && a <= 8'h1E)
        chk(rdCount == r0, "R10 no read strobe in reserved", rdCount - r0, 0);
    end

    // read sweep, 4-wire (R2 R6)
    for (int a = 0; a < 128; a++) begin
      startTxn(1'b1, a[1]);
      xfer(8'(a), 8, rb, ea, el);
      xfer(8'h00, 8, rb, ea, el);
      chk(rb == (isRsv(a) ? 8'h00 : pat(a)), "R2/R6 read byte", rb, isRsv(a) ? 0 : pat(a));
      endTxn();
    end

    // clock window write burst, 3-wire: 9E,9F,80,81 (R7 R8)
    w0 = wrCount;
    startTxn(1'b0, 1'b0);
    xfer(8'h9E, 8, rb, ea, el);
    xfer(8'h11, 8, rb, ea, el);
    xfer(8'h22, 8, rb, ea, el);
    xfer(8'h33, 8, rb, ea, el);
    xfer(8'h44, 8, rb, ea, el);
    endTxn();
    chk(wrCount - w0 == 2, "R8 burst write count", wrCount - w0, 2);
    chk(mem[0] == 8'h33, "R8 write wrap to 80h", mem[0], 8'h33);
    chk(mem[1] == 8'h44, "R7 write increment", mem[1], 8'h44);

    // RAM window write burst, 4-wire idle high: FE,FF,A0 (R9)
    startTxn(1'b1, 1'b1);
    xfer(8'hFE, 8, rb, ea, el);
    xfer(8'hAA, 8, rb, ea, el);
    xfer(8'hBB, 8, rb, ea, el);
    xfer(8'hCC, 8, rb, ea, el);
    endTxn();
    chk(mem[7'h7E] == 8'hAA && mem[7'h7F] == 8'hBB, "R9 RAM top", {mem[7'h7E], mem[7'h7F]}, 16'hAABB);
    chk(mem[7'h20] == 8'hCC, "R9 write wrap to A0h", mem[7'h20], 8'hCC);

    // clock window read burst, 4-wire: 1E,1F,00,01 (R8 R10)
    startTxn(1'b1, 1'b0);
    xfer(8'h1E, 8, rb, ea, el);
    xfer(8'h00, 8, rb, ea, el);
    chk(rb == 8'h00, "R10 reserved 1Eh", rb, 0);
    xfer(8'h00, 8, rb, ea, el);
    chk(rb == 8'h00, "R10 reserved 1Fh", rb, 0);
    xfer(8'h00, 8, rb, ea, el);
    chk(rb == 8'h33, "R8 read wrap to 00h", rb, 8'h33);
    xfer(8'h00, 8, rb, ea, el);
    chk(rb == 8'h44, "R7 read increment", rb, 8'h44);
    endTxn();

    // RAM window read burst, 3-wire: 7E,7F,20 (R9)
    startTxn(1'b0, 1'b0);
    xfer(8'h7E, 8, rb, ea, el);
    xfer(8'h00, 8, rb, ea, el);
    chk(rb == 8'hAA, "R9 read 7Eh", rb, 8'hAA);
    xfer(8'h00, 8, rb, ea, el);
    chk(rb == 8'hBB, "R9 read 7Fh", rb, 8'hBB);
    xfer(8'h00, 8, rb, ea, el);
    chk(rb == 8'hCC, "R9 read wrap to 20h", rb, 8'hCC);
    endTxn();

    // partial write byte dropped (R11)
    w0 = wrCount;
    startTxn(1'b1, 1'b0);
    xfer(8'h85, 8, rb, ea, el);
    xfer(8'hF0, 4, rb, ea, el);
    sclkR = 1'b0;
    endTxn();
    chk(wrCount == w0, "R11 partial byte gives no write", wrCount - w0, 0);
    chk(mem[5] == pat(5), "R11 target unchanged", mem[5], pat(5));
    startTxn(1'b1, 1'b0);
    xfer(8'h85, 8, rb, ea, el);
    xfer(8'h5E, 8, rb, ea, el);
    endTxn();
    chk(mem[5] == 8'h5E, "R11 fresh command after abort", mem[5], 8'h5E);

    // read aborted mid-byte releases the line (R11 R4)
    startTxn(1'b0, 1'b0);
    xfer(8'h03, 8, rb, ea, el);
    xfer(8'h00, 3, rb, ea, el);
    chk(el, "R4 driving mid-read", el, 1);
    sclkR = 1'b0;
    endTxn();
    chk(sdoEn == 0, "R11 abort releases line", sdoEn, 0);
    chk(regWr == 0 && regRd == 0, "R11 idle strobes", {regWr, regRd}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule